// File: doc/BRIEF.md
# Packed Lane Arithmetic Unit

This unit is one execution slot of a wide datapath. Every cycle it may take one operation code and two 32-bit sources. It treats the sources as four independent byte lanes or two halfword lanes, or it treats them as a whole word for the rotate and shift operations. One registered result comes back one clock later. The operations are:

- per-lane unsigned byte distance
- lane-parallel multiplies
- per-byte population count
- rotate
- whole-byte shifts
- a variable shift whose direction comes from the sign of the amount

The result port is 64 bits wide. The multiply operations fill all 64 bits. Every other operation returns a 32-bit value in the low word, with zeros above it.

An upstream issue stage raises the valid strobe with the operation and its sources. A downstream writeback stage takes the result in the cycle that the output valid is high. No operation stalls, and a new operation can be accepted on every clock.

Top module: `pklane_alu`

## Requirements
- R1: While reset is asserted, and after it is released, the output valid is 0 and the result is 0 until the first accepted operation.
- R2: An operation presented with input valid high appears on the outputs after exactly one rising clock edge, with output valid high. In a cycle with input valid low, the next output valid is 0 and the result register keeps its previous value. Back-to-back operations complete one per cycle.
- R3: Operation code 0 returns, for each byte lane i (bits 8i+7..8i), the unsigned absolute difference |a_i - b_i|, with no borrow between lanes.
- R4: Operation code 1 multiplies the two halfword lanes as signed 16-bit values. The low-lane product goes in result bits 31..0 and the high-lane product in bits 63..32, each as a 32-bit two's-complement value.
- R5: Operation code 2 multiplies the four byte lanes as unsigned 8-bit values. The product of lane i goes in result bits 16i+15..16i, so no lane product can exceed 0xFE01.
- R6: Operation code 3 returns, in each byte lane, the number of set bits of source a in that same lane (0 to 8). Source b is ignored.
- R7: Operation code 4 rotates source a left by b[4:0] bit positions. The upper bits of b are ignored.
- R8: Operation code 5 shifts source a left by b[1:0] whole bytes. Operation code 6 shifts it right, logically, by b[1:0] whole bytes. Vacated bytes are zero in both cases.
- R9: Operation code 7 reads source b as a signed 32-bit amount. Zero or a positive amount shifts a left by that amount. A negative amount shifts a right arithmetically by its magnitude. The magnitude is clamped to 31, including for the most negative amount.
- R10: For operation codes 0 and 3 to 7, result bits 63..32 are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operation present this cycle |
| in_op | input | 3 | Operation code (0 to 7) |
| in_a | input | 32 | First source word |
| in_b | input | 32 | Second source word or shift amount |
| out_vld | output | 1 | Result valid, one cycle after in_vld |
| out_res | output | 64 | Registered result |

## Verification
The checks that look back one cycle at the operation code assume that the code and the sources are stable across the whole cycle in which input valid is high. They also assume every code is one of the eight defined values. The bench changes inputs only on falling edges and drives only defined codes, so both assumptions hold. The hold check assumes that an idle cycle may carry arbitrary sources and codes. The bench therefore drives nonzero junk during idle cycles, so that a wrongly loaded register becomes visible.

// File: rtl/pklane_pkg.sv
package pklane_pkg;
    localparam int OPW = 3;

    typedef enum logic [OPW-1:0] {
        OP_ABSD8 = 3'd0,
        OP_MUL16 = 3'd1,
        OP_MUL8  = 3'd2,
        OP_POPC8 = 3'd3,
        OP_ROTL  = 3'd4,
        OP_BYTL  = 3'd5,
        OP_BYTR  = 3'd6,
        OP_SSHF  = 3'd7
    } pk_op_e;
endpackage

// File: rtl/pklane_mul.sv
module pklane_mul #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]   src_a,
    input  logic [DATA_W-1:0]   src_b,
    output logic [2*DATA_W-1:0] prod_h,
    output logic [2*DATA_W-1:0] prod_b
);
    localparam int NH = DATA_W / 16;
    localparam int NB = DATA_W / 8;

    // signed halfword products, each 32 bits wide
    for (genvar h = 0; h < NH; h++) begin : g_half
        logic signed [15:0] ha, hb;
        assign ha = src_a[16*h +: 16];
        assign hb = src_b[16*h +: 16];
        assign prod_h[32*h +: 32] = ha * hb;
    end

    // unsigned byte products, each 16 bits wide
    for (genvar i = 0; i < NB; i++) begin : g_byte
        logic [7:0] ba, bb;
        assign ba = src_a[8*i +: 8];
        assign bb = src_b[8*i +: 8];
        assign prod_b[16*i +: 16] = ba * bb;
    end
endmodule

// File: rtl/pklane_bytewise.sv
module pklane_bytewise #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] absd,
    output logic [DATA_W-1:0] popc
);
    localparam int NB = DATA_W / 8;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [7:0] la, lb;
        logic [3:0] cnt;
        assign la = src_a[8*i +: 8];
        assign lb = src_b[8*i +: 8];
        assign absd[8*i +: 8] = (la >= lb) ? (la - lb) : (lb - la);

        always_comb begin
            cnt = '0;
            for (int k = 0; k < 8; k++) begin
                cnt = cnt + {3'b000, la[k]};
            end
        end
        assign popc[8*i +: 8] = {4'b0000, cnt};
    end
endmodule

// File: rtl/pklane_shift.sv
module pklane_shift #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] rot,
    output logic [DATA_W-1:0] byt_l,
    output logic [DATA_W-1:0] byt_r,
    output logic [DATA_W-1:0] sshf
);
    localparam int SHW = $clog2(DATA_W);
    localparam int NB  = DATA_W / 8;
    localparam int BSW = $clog2(NB);
    localparam logic [DATA_W:0] MAXAMT = (DATA_W+1)'(DATA_W - 1);

    logic [2*DATA_W-1:0] dbl;
    logic [DATA_W:0]     b_ext;
    logic [DATA_W:0]     mag;
    logic [SHW-1:0]      amt;
    logic [BSW+2:0]      bsh;

    always_comb begin
        dbl   = {src_a, src_a} << src_b[SHW-1:0];
        rot   = dbl[2*DATA_W-1:DATA_W];

        bsh   = {src_b[BSW-1:0], 3'b000};
        byt_l = src_a << bsh;
        byt_r = src_a >> bsh;

        // sign-directed shift: magnitude kept one bit wider than the amount
        b_ext = {src_b[DATA_W-1], src_b};
        mag   = src_b[DATA_W-1] ? (~b_ext + 1'b1) : b_ext;
        amt   = (mag > MAXAMT) ? SHW'(DATA_W - 1) : mag[SHW-1:0];
        if (src_b[DATA_W-1]) begin
            sshf = $signed(src_a) >>> amt;
        end else begin
            sshf = src_a << amt;
        end
    end
endmodule

// File: rtl/pklane_alu.sv
module pklane_alu
    import pklane_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_vld,
    input  logic [OPW-1:0]        in_op,
    input  logic [DATA_W-1:0]     in_a,
    input  logic [DATA_W-1:0]     in_b,
    output logic                  out_vld,
    output logic [2*DATA_W-1:0]   out_res
);
    localparam int RES_W = 2 * DATA_W;
    localparam int NB    = DATA_W / 8;

    typedef struct packed {
        logic             vld;
        logic [RES_W-1:0] res;
    } stage_t;

    stage_t st_d, st_q;

    logic [RES_W-1:0]  prod_h, prod_b;
    logic [DATA_W-1:0] absd, popc, rot, byt_l, byt_r, sshf;
    pk_op_e            op;

    assign op = pk_op_e'(in_op);

    pklane_mul #(.DATA_W(DATA_W)) u_mul (
        .src_a (in_a),
        .src_b (in_b),
        .prod_h(prod_h),
        .prod_b(prod_b)
    );

    pklane_bytewise #(.DATA_W(DATA_W)) u_bytewise (
        .src_a(in_a),
        .src_b(in_b),
        .absd (absd),
        .popc (popc)
    );

    pklane_shift #(.DATA_W(DATA_W)) u_shift (
        .src_a(in_a),
        .src_b(in_b),
        .rot  (rot),
        .byt_l(byt_l),
        .byt_r(byt_r),
        .sshf (sshf)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            unique case (op)
                OP_ABSD8: st_d.res = {{DATA_W{1'b0}}, absd};
                OP_MUL16: st_d.res = prod_h;
                OP_MUL8:  st_d.res = prod_b;
                OP_POPC8: st_d.res = {{DATA_W{1'b0}}, popc};
                OP_ROTL:  st_d.res = {{DATA_W{1'b0}}, rot};
                OP_BYTL:  st_d.res = {{DATA_W{1'b0}}, byt_l};
                OP_BYTR:  st_d.res = {{DATA_W{1'b0}}, byt_r};
                OP_SSHF:  st_d.res = {{DATA_W{1'b0}}, sshf};
                default:  st_d.res = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.vld;
    assign out_res = st_q.res;

    // R2: accepted work shows up after one edge
    a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    // R2: idle cycles clear valid and leave the result alone
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> (!out_vld && $stable(out_res)));

    // R10: single-word results leave the upper word clear
    a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_op != OP_MUL16 && in_op != OP_MUL8)
        |=> (out_res[RES_W-1:DATA_W] == '0));

    // R9: a zero amount passes the source through unchanged
    a_r9_zero_amount: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_op == OP_SSHF && in_b == '0)
        |=> (out_res == {{DATA_W{1'b0}}, $past(in_a)}));

    for (genvar i = 0; i < NB; i++) begin : g_chk
        // R5: an unsigned 8x8 lane product cannot exceed 255*255
        a_r5_lane_bound: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld && in_op == OP_MUL8) |=> (out_res[16*i +: 16] <= 16'hFE01));
        // R6: a lane popcount is at most eight
        a_r6_count_range: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld && in_op == OP_POPC8) |=> (out_res[8*i +: 8] <= 8'd8));
    end
endmodule

// File: tb/pklane_alu_tb.sv
`timescale 1ns/1ps
module pklane_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_vld;
    logic [2:0]  in_op;
    logic [31:0] in_a, in_b;
    logic        out_vld;
    logic [63:0] out_res;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    pklane_alu dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (in_vld),
        .in_op  (in_op),
        .in_a   (in_a),
        .in_b   (in_b),
        .out_vld(out_vld),
        .out_res(out_res)
    );

    function automatic logic [63:0] model(input logic [2:0] op,
                                          input logic [31:0] a,
                                          input logic [31:0] b);
        logic [63:0] r;
        longint      sb, m;
        int          cnt;
        r = '0;
        case (op)
            3'd0: for (int i = 0; i < 4; i++) begin
                int x, y;
                x = a[8*i +: 8];
                y = b[8*i +: 8];
                r[8*i +: 8] = 8'((x > y) ? x - y : y - x);
            end
            3'd1: for (int h = 0; h < 2; h++) begin
                longint x, y;
                x = longint'($signed(a[16*h +: 16]));
                y = longint'($signed(b[16*h +: 16]));
                r[32*h +: 32] = 32'(x * y);
            end
            3'd2: for (int i = 0; i < 4; i++) begin
                int x, y;
                x = a[8*i +: 8];
                y = b[8*i +: 8];
                r[16*i +: 16] = 16'(x * y);
            end
            3'd3: for (int i = 0; i < 4; i++) begin
                cnt = 0;
                for (int k = 0; k < 8; k++) cnt += a[8*i + k];
                r[8*i +: 8] = 8'(cnt);
            end
            3'd4: begin
                logic [31:0] t;
                t = a;
                for (int k = 0; k < int'(b[4:0]); k++) t = {t[30:0], t[31]};
                r[31:0] = t;
            end
            3'd5: r[31:0] = a << (8 * b[1:0]);
            3'd6: r[31:0] = a >> (8 * b[1:0]);
            default: begin
                sb = longint'($signed(b));
                m  = (sb < 0) ? -sb : sb;
                if (m > 31) m = 31;
                if (sb >= 0) r[31:0] = a << m;
                else         r[31:0] = 32'($signed(a) >>> m);
            end
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive on a falling edge, sample at the next falling edge
    task automatic run_op(input string req, input logic [2:0] op,
                          input logic [31:0] a, input logic [31:0] b);
        in_vld = 1'b1;
        in_op  = op;
        in_a   = a;
        in_b   = b;
        @(negedge clk);
        check("R2", {63'd0, out_vld}, 64'd1);
        check(req, out_res, model(op, a, b));
        in_vld = 1'b0;
    endtask

    task automatic t_reset;
        check("R1", {63'd0, out_vld}, 64'd0);
        check("R1", out_res, 64'd0);
    endtask

    task automatic t_idle_hold;
        logic [63:0] prev;
        prev   = out_res;
        in_vld = 1'b0;
        in_op  = 3'd2;
        in_a   = 32'hDEAD_BEEF;
        in_b   = 32'h1234_5678;
        @(negedge clk);
        check("R2", {63'd0, out_vld}, 64'd0);
        check("R2", out_res, prev);
    endtask

    task automatic t_absd;
        run_op("R3", 3'd0, 32'h10FF_0080, 32'h2001_FF80);
        check("R3", out_res, 64'h0000_0000_10FE_FF00);
        run_op("R3", 3'd0, 32'h0000_0000, 32'hFFFF_FFFF);
        check("R10", out_res[63:32], 64'd0);
    endtask

    task automatic t_mul16;
        run_op("R4", 3'd1, 32'h8000_7FFF, 32'h8000_FFFF);
        check("R4", out_res, 64'h4000_0000_FFFF_8001);
        run_op("R4", 3'd1, 32'h0003_FFFE, 32'hFFFB_0007);
    endtask

    task automatic t_mul8;
        run_op("R5", 3'd2, 32'hFFFF_0102, 32'hFF01_0304);
        check("R5", out_res, 64'hFE01_00FF_0003_0008);
        run_op("R5", 3'd2, 32'h8040_2010, 32'h0280_FF11);
    endtask

    task automatic t_popc;
        run_op("R6", 3'd3, 32'hFF0F_0100, 32'hFFFF_FFFF);
        check("R6", out_res, 64'h0000_0000_0804_0100);
        run_op("R6", 3'd3, 32'hA55A_8001, 32'h0);
    endtask

    task automatic t_rot;
        run_op("R7", 3'd4, 32'h8000_0001, 32'hFFFF_FFE0);
        run_op("R7", 3'd4, 32'h1234_5678, 32'h0000_0004);
        check("R7", out_res, 64'h0000_0000_2345_6781);
        run_op("R7", 3'd4, 32'h8000_0001, 32'h0000_001F);
    endtask

    task automatic t_bytes;
        run_op("R8", 3'd5, 32'h1122_3344, 32'hFFFF_FF01);
        check("R8", out_res, 64'h0000_0000_2233_4400);
        run_op("R8", 3'd5, 32'h1122_3344, 32'h0000_0003);
        run_op("R8", 3'd6, 32'h8122_3344, 32'h0000_0002);
        check("R8", out_res, 64'h0000_0000_0000_8122);
        run_op("R10", 3'd6, 32'hFFFF_FFFF, 32'h0);
    endtask

    task automatic t_sshf;
        run_op("R9", 3'd7, 32'h0000_00F1, 32'h0000_0004);
        run_op("R9", 3'd7, 32'hF000_0000, 32'hFFFF_FFFC);
        check("R9", out_res, 64'h0000_0000_FF00_0000);
        run_op("R9", 3'd7, 32'h0000_0001, 32'h0000_0028);
        check("R9", out_res, 64'h0000_0000_8000_0000);
        run_op("R9", 3'd7, 32'h8000_0000, 32'hFFFF_FF9C);
        check("R9", out_res, 64'h0000_0000_FFFF_FFFF);
        run_op("R9", 3'd7, 32'h8000_0000, 32'h8000_0000);
        run_op("R9", 3'd7, 32'h4000_0000, 32'h8000_0000);
        check("R9", out_res, 64'd0);
        run_op("R9", 3'd7, 32'hCAFE_F00D, 32'h0);
    endtask

    task automatic t_stream;
        // consecutive valid cycles, one result per clock
        run_op("R2", 3'd2, 32'h0102_0304, 32'h0506_0708);
        run_op("R2", 3'd0, 32'h0102_0304, 32'h0506_0708);
        run_op("R2", 3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n  = 1'b0;
        in_vld = 1'b0;
        in_op  = 3'd0;
        in_a   = 32'h5555_AAAA;
        in_b   = 32'h3333_CCCC;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_absd();
        t_idle_hold();
        t_mul16();
        t_mul8();
        t_idle_hold();
        t_popc();
        t_rot();
        t_bytes();
        t_sshf();
        t_idle_hold();
        t_stream();
        t_idle_hold();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule